// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger

This block watches the processor's instruction and operand streams and raises a debug response when a programmed breakpoint condition holds. It has three comparators. The first matches the program counter against a base value under a bit mask. The second tests whether an operand address lies between a lower and an upper bound. The third matches operand data against a base value under a bit mask. Each of two trigger levels takes any subset of these comparators, can flip the sense of each one, and joins them with either AND or OR.

In one-level mode, level 1 alone decides when the response fires. In two-level mode, a level 1 hit only arms the unit, and the response fires on the first level 2 hit after that. The response is a single-cycle pulse. It goes out either as a halt request to the processor or as a top-priority debug interrupt. The external debug serial interface and supervisor software share one write-only register port. Any write to that port drops the armed state.

Top module: `dbg_trig_unit`

## Requirements
- R1: The program-counter comparator hits on a cycle with `pc_valid` high when ((pc XOR pc_base) AND pc_mask) is zero; a mask bit of 1 means that bit is compared. It never hits when `pc_valid` is low.
- R2: The data comparator applies the same masked-equality rule to `opd_data`, using the data base and data mask registers, and only hits on cycles with `opd_valid` high.
- R3: The range comparator hits when `opd_valid` is high and lo <= `opd_addr` <= hi, with both bounds inclusive.
- R4: Each level uses only the comparators its enable field selects (bit 0 PC, bit 1 range, bit 2 data). A level with no comparator enabled never hits.
- R5: A level's combine bit chooses between two rules. With 0 (OR), the level hits if any enabled term is true. With 1 (AND), it hits only if every enabled term is true.
- R6: A set invert bit makes that comparator's term true on a valid cycle where the comparator does not match. On a cycle where its stream is not valid, the term is false.
- R7: In one-level mode, a level 1 hit produces the response on the next clock, and level 2 has no effect.
- R8: In two-level mode, a level 1 hit while unarmed sets `trig_armed` on the next clock and produces no response. If level 1 and level 2 both hit in the same cycle while unarmed, the unit only arms. A level 2 hit while armed produces the response on the next clock and clears `trig_armed`. A level 2 hit while unarmed does nothing.
- R9: The response select bit picks the output: 0 pulses `halt_req`, 1 pulses `dbg_irq`. Each hit gives a one-clock pulse, and the two outputs are never high together. All outputs are low after reset.
- R10: A register write clears `trig_armed` on the next clock. No arming or response happens in the cycle of the write.
- R11: Control register (address 6) layout, from bit 0 upward:
  - bits 2:0: level 1 enable
  - bits 5:3: level 1 invert
  - bit 6: level 1 AND
  - bits 9:7: level 2 enable
  - bits 12:10: level 2 invert
  - bit 13: level 2 AND
  - bit 14: two-level mode
  - bit 15: response select

  The other registers are at these addresses:
  - 0: PC base
  - 1: PC mask
  - 2: range low
  - 3: range high
  - 4: data base
  - 5: data mask

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe (debug serial or supervisor path) |
| wr_addr | input | 3 | Register select |
| wr_data | input | RW | Write data |
| pc_valid | input | 1 | Program counter sample is valid |
| pc | input | AW | Program counter |
| opd_valid | input | 1 | Operand access is valid |
| opd_addr | input | AW | Operand address |
| opd_data | input | DW | Operand data |
| halt_req | output | 1 | One-cycle halt request pulse |
| dbg_irq | output | 1 | One-cycle debug interrupt pulse |
| trig_armed | output | 1 | Level 1 has fired in two-level mode and level 2 is awaited |

## Verification
The embedded properties check several rules on every cycle. Halt and interrupt never pulse together. A write always clears the armed state. In two-level mode a response must be preceded by an armed cycle. Arming happens only in two-level mode. A level with nothing enabled never hits, and a range hit always comes with a valid access. Only the bench scenarios can show the actual match arithmetic: mask semantics, inclusive bounds and inverted terms. They also cover the AND/OR selection, the ordering between the two levels, and the choice of halt or interrupt, each against hand-derived expected outputs.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

   localparam int NUM_CMP = 3;
   localparam int CMP_PC  = 0;
   localparam int CMP_RNG = 1;
   localparam int CMP_DAT = 2;

   typedef enum logic [2:0] {
      REG_PC_BASE  = 3'd0,
      REG_PC_MASK  = 3'd1,
      REG_RNG_LO   = 3'd2,
      REG_RNG_HI   = 3'd3,
      REG_DAT_BASE = 3'd4,
      REG_DAT_MASK = 3'd5,
      REG_CTL      = 3'd6
   } reg_sel_e;

   // packed MSB first: bit 15 down to bit 0
   typedef struct packed {
      logic                resp_irq;
      logic                two_lvl;
      logic                l2_and;
      logic [NUM_CMP-1:0]  l2_inv;
      logic [NUM_CMP-1:0]  l2_en;
      logic                l1_and;
      logic [NUM_CMP-1:0]  l1_inv;
      logic [NUM_CMP-1:0]  l1_en;
   } trig_ctl_t;

   localparam int CTL_W = $bits(trig_ctl_t);

endpackage

// File: rtl/dbg_mask_cmp.sv
module dbg_mask_cmp #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid,
   input  logic [W-1:0] value,
   input  logic [W-1:0] base,
   input  logic [W-1:0] mask,
   output logic         hit
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dbg_mask_cmp: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] diff;
   assign diff = (value ^ base) & mask;
   assign hit  = valid && (diff == '0);

   // R1 R2
   hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> valid);
endmodule

// File: rtl/dbg_range_cmp.sv
module dbg_range_cmp #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid,
   input  logic [W-1:0] addr,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic         hit
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dbg_range_cmp: W must be at least 1");
      end
   endgenerate

   logic above_lo, below_hi;
   assign above_lo = (addr >= lo);
   assign below_hi = (addr <= hi);
   assign hit      = valid && above_lo && below_hi;

   // R3
   rng_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> valid);
endmodule

// File: rtl/dbg_level_eval.sv
module dbg_level_eval #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] vld,
   input  logic [N-1:0] hit,
   input  logic [N-1:0] en,
   input  logic [N-1:0] inv,
   input  logic         use_and,
   output logic         fire
);
   generate
      if (N < 1) begin : g_bad_n
         $error("dbg_level_eval: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] term;
   logic [N-1:0] pass;

   for (genvar i = 0; i < N; i++) begin : g_term
      assign term[i] = vld[i] && (hit[i] ^ inv[i]);
      assign pass[i] = term[i] || !en[i];
   end

   logic any_on, all_on;
   assign any_on = |(term & en);
   assign all_on = (en != '0) && (&pass);
   assign fire   = use_and ? all_on : any_on;

   // R4
   no_enable_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (en != '0));
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
   import dbg_trig_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int RW = (AW > DW) ? AW : DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [RW-1:0] wr_data,
   input  logic          pc_valid,
   input  logic [AW-1:0] pc,
   input  logic          opd_valid,
   input  logic [AW-1:0] opd_addr,
   input  logic [DW-1:0] opd_data,
   output logic          halt_req,
   output logic          dbg_irq,
   output logic          trig_armed
);
   generate
      if (RW < CTL_W) begin : g_bad_rw
         $error("dbg_trig_unit: write port narrower than control register");
      end
   endgenerate

   // register file
   logic [AW-1:0] pc_base_q, pc_mask_q, rng_lo_q, rng_hi_q;
   logic [DW-1:0] dat_base_q, dat_mask_q;
   trig_ctl_t     ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_base_q  <= '0;
         pc_mask_q  <= '0;
         rng_lo_q   <= '0;
         rng_hi_q   <= '0;
         dat_base_q <= '0;
         dat_mask_q <= '0;
         ctl_q      <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_addr))
            REG_PC_BASE:  pc_base_q  <= wr_data[AW-1:0];
            REG_PC_MASK:  pc_mask_q  <= wr_data[AW-1:0];
            REG_RNG_LO:   rng_lo_q   <= wr_data[AW-1:0];
            REG_RNG_HI:   rng_hi_q   <= wr_data[AW-1:0];
            REG_DAT_BASE: dat_base_q <= wr_data[DW-1:0];
            REG_DAT_MASK: dat_mask_q <= wr_data[DW-1:0];
            REG_CTL:      ctl_q      <= trig_ctl_t'(wr_data[CTL_W-1:0]);
            default: ;
         endcase
      end
   end

   // comparators
   logic [NUM_CMP-1:0] cmp_hit, cmp_vld;
   assign cmp_vld[CMP_PC]  = pc_valid;
   assign cmp_vld[CMP_RNG] = opd_valid;
   assign cmp_vld[CMP_DAT] = opd_valid;

   dbg_mask_cmp #(.W(AW)) u_pc_cmp (
      .clk(clk), .rst_n(rst_n), .valid(pc_valid), .value(pc),
      .base(pc_base_q), .mask(pc_mask_q), .hit(cmp_hit[CMP_PC]));

   dbg_range_cmp #(.W(AW)) u_rng_cmp (
      .clk(clk), .rst_n(rst_n), .valid(opd_valid), .addr(opd_addr),
      .lo(rng_lo_q), .hi(rng_hi_q), .hit(cmp_hit[CMP_RNG]));

   dbg_mask_cmp #(.W(DW)) u_dat_cmp (
      .clk(clk), .rst_n(rst_n), .valid(opd_valid), .value(opd_data),
      .base(dat_base_q), .mask(dat_mask_q), .hit(cmp_hit[CMP_DAT]));

   // two trigger levels
   logic [1:0] lvl_fire;
   for (genvar g = 0; g < 2; g++) begin : g_lvl
      logic [NUM_CMP-1:0] en_sel, inv_sel;
      logic               and_sel;
      if (g == 0) begin : g_l1
         assign en_sel  = ctl_q.l1_en;
         assign inv_sel = ctl_q.l1_inv;
         assign and_sel = ctl_q.l1_and;
      end else begin : g_l2
         assign en_sel  = ctl_q.l2_en;
         assign inv_sel = ctl_q.l2_inv;
         assign and_sel = ctl_q.l2_and;
      end
      dbg_level_eval #(.N(NUM_CMP)) u_lvl (
         .clk(clk), .rst_n(rst_n), .vld(cmp_vld), .hit(cmp_hit),
         .en(en_sel), .inv(inv_sel), .use_and(and_sel), .fire(lvl_fire[g]));
   end

   // sequencer
   logic armed_q, fire_now, arm_set;
   logic halt_q, irq_q;

   assign fire_now = !wr_en && (ctl_q.two_lvl ? (armed_q && lvl_fire[1]) : lvl_fire[0]);
   assign arm_set  = !wr_en && ctl_q.two_lvl && !armed_q && lvl_fire[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         halt_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (wr_en || fire_now) armed_q <= 1'b0;
         else if (arm_set)      armed_q <= 1'b1;
         halt_q <= fire_now && !ctl_q.resp_irq;
         irq_q  <= fire_now &&  ctl_q.resp_irq;
      end
   end

   assign halt_req   = halt_q;
   assign dbg_irq    = irq_q;
   assign trig_armed = armed_q;

   // R9
   resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt_req && dbg_irq));
   // R10
   wr_clears_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !trig_armed);
   // R8
   l2_after_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((halt_req || dbg_irq) && $past(ctl_q.two_lvl)) |-> $past(armed_q));
   // R7
   arm_only_two_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(ctl_q.two_lvl));
endmodule

// File: tb/tb_dbg_trig_unit.sv
module tb_dbg_trig_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          pc_valid = 1'b0;
   logic [AW-1:0] pc = '0;
   logic          opd_valid = 1'b0;
   logic [AW-1:0] opd_addr = '0;
   logic [DW-1:0] opd_data = '0;
   logic          halt_req, dbg_irq, trig_armed;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_trig_unit #(.AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pc_valid(pc_valid), .pc(pc),
      .opd_valid(opd_valid), .opd_addr(opd_addr), .opd_data(opd_data),
      .halt_req(halt_req), .dbg_irq(dbg_irq), .trig_armed(trig_armed));

   typedef struct {
      logic  h;
      logic  i;
      logic  a;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int total = 0;
   int bad = 0;
   bit done = 0;

   // monitor: compare one expected item after each edge that has one queued
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         total++;
         if (halt_req !== e.h || dbg_irq !== e.i || trig_armed !== e.a) begin
            bad++;
            $display("FAIL %s: actual halt=%b irq=%b armed=%b expected halt=%b irq=%b armed=%b",
                     e.tag, halt_req, dbg_irq, trig_armed, e.h, e.i, e.a);
         end
      end
   end

   task automatic step(input logic pv, input logic [31:0] p,
                       input logic ov, input logic [31:0] oa, input logic [31:0] od,
                       input logic eh, input logic ei, input logic ea, input string tag);
      exp_t e;
      @(negedge clk);
      wr_en = 1'b0; pc_valid = pv; pc = p;
      opd_valid = ov; opd_addr = oa; opd_data = od;
      e.h = eh; e.i = ei; e.a = ea; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      pc_valid = 1'b0; opd_valid = 1'b0;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (halt_req !== 1'b0 || dbg_irq !== 1'b0 || trig_armed !== 1'b0) begin
         bad++;
         $display("FAIL R9 reset: actual %b%b%b expected 000", halt_req, dbg_irq, trig_armed);
      end
      rst_n = 1'b1;

      // R1 PC mask compare
      wr(3'd0, 32'h0000_1000);
      wr(3'd1, 32'hFFFF_FFF0);
      wr(3'd6, 32'h0001);
      step(1, 32'h1008, 0, 0, 0, 1, 0, 0, "R1 masked pc hit");
      step(1, 32'h1010, 0, 0, 0, 0, 0, 0, "R1 pc miss");
      step(0, 32'h1008, 0, 0, 0, 0, 0, 0, "R1 pc not valid");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R9 pulse ends");
      // R9 interrupt select
      wr(3'd6, 32'h8001);
      step(1, 32'h100F, 0, 0, 0, 0, 1, 0, "R9 irq select");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R9 irq pulse ends");

      // R2 data mask compare
      wr(3'd4, 32'h0000_AB00);
      wr(3'd5, 32'h0000_FF00);
      wr(3'd6, 32'h0004);
      step(0, 0, 1, 0, 32'hAB55, 1, 0, 0, "R2 data hit");
      step(0, 0, 1, 0, 32'hAC00, 0, 0, 0, "R2 data miss");
      step(0, 0, 0, 0, 32'hAB00, 0, 0, 0, "R2 data not valid");

      // R3 inclusive range
      wr(3'd2, 32'h200);
      wr(3'd3, 32'h2FF);
      wr(3'd6, 32'h0002);
      step(0, 0, 1, 32'h200, 0, 1, 0, 0, "R3 low bound");
      step(0, 0, 1, 32'h2FF, 0, 1, 0, 0, "R3 high bound");
      step(0, 0, 1, 32'h1FF, 0, 0, 0, 0, "R3 below");
      step(0, 0, 1, 32'h300, 0, 0, 0, 0, "R3 above");
      step(0, 0, 0, 32'h250, 0, 0, 0, 0, "R3 not valid");

      // R4 enables
      wr(3'd6, 32'h0000);
      step(1, 32'h1008, 1, 32'h250, 32'hAB00, 0, 0, 0, "R4 none enabled");
      wr(3'd6, 32'h0001);
      step(1, 32'h1008, 1, 32'h900, 32'h0000, 1, 0, 0, "R4 subset ignores others");

      // R5 combine
      wr(3'd6, 32'h0043);
      step(1, 32'h1008, 1, 32'h250, 0, 1, 0, 0, "R5 and both true");
      step(1, 32'h1008, 1, 32'h400, 0, 0, 0, 0, "R5 and one false");
      wr(3'd6, 32'h0003);
      step(1, 32'h1008, 1, 32'h400, 0, 1, 0, 0, "R5 or one true");

      // R6 invert
      wr(3'd6, 32'h0012);
      step(0, 0, 1, 32'h400, 0, 1, 0, 0, "R6 inverted miss fires");
      step(0, 0, 1, 32'h250, 0, 0, 0, 0, "R6 inverted hit quiet");
      step(0, 0, 0, 32'h400, 0, 0, 0, 0, "R6 invalid stays false");

      // R8 two-level sequencing (R11 control layout)
      wr(3'd6, 32'h4201);
      step(0, 0, 1, 0, 32'hAB11, 0, 0, 0, "R8 l2 before l1 ignored");
      step(1, 32'h1008, 0, 0, 0, 0, 0, 1, "R8 l1 arms");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R8 arm held");
      step(0, 0, 1, 0, 32'hAB11, 1, 0, 0, "R8 l2 fires and disarms");
      step(0, 0, 1, 0, 32'hAB11, 0, 0, 0, "R8 no refire unarmed");
      step(1, 32'h1008, 1, 0, 32'hAB11, 0, 0, 1, "R8 same cycle only arms");
      step(0, 0, 1, 0, 32'hAB11, 1, 0, 0, "R8 second fire");

      // R10 write clears armed state
      step(1, 32'h1008, 0, 0, 0, 0, 0, 1, "R10 arm before write");
      wr(3'd5, 32'h0000_FF00);
      step(0, 0, 1, 0, 32'hAB11, 0, 0, 0, "R10 disarmed by write");

      // R10 write suppresses firing in its cycle
      wr(3'd6, 32'h0001);
      @(negedge clk);
      pc_valid = 1'b1; pc = 32'h1008; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'hFFFF_FFF0;
      begin
         exp_t e;
         e.h = 0; e.i = 0; e.a = 0; e.tag = "R10 no fire in write cycle";
         exp_q.push_back(e);
      end
      step(1, 32'h1008, 0, 0, 0, 1, 0, 0, "R10 fires after write");

      // R7 one-level mode ignores level 2
      wr(3'd6, 32'h0201);
      step(0, 0, 1, 0, 32'hAB11, 0, 0, 0, "R7 level2 unused");
      step(1, 32'h1008, 0, 0, 0, 1, 0, 0, "R7 level1 fires no arm");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R7 idle");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule